// File: doc/BRIEF.md
# Alignment Right Shifter with Sticky Merge

This combinational block moves a data word toward its least significant end by a variable distance, filling the vacated top positions with zeros. Bits that fall off the bottom are not simply lost. They are OR-reduced into a single sticky indicator, and that indicator is forced into the least significant bit of the result. A floating-point adder uses this step when it aligns the smaller operand's significand, so that the later rounding stage still knows whether any nonzero bits were dropped.

The data width is a parameter and must be a power of two. The distance field is exactly its base-2 logarithm wide, so every distance from zero to one less than the width can be requested. There is no clock and no storage: the result follows the inputs in the same evaluation step.

Top module: `align_sticky_shifter`

## Requirements
- R1: With default parameters the word is 32 bits wide, and every distance from 0 to 31 produces a correct result.
- R2: The distance port is log2(WIDTH) bits wide (5 bits by default), and every code on it is a legal distance.
- R3: Apart from bit 0, the result equals the input logically shifted right by the distance, and the top `distance` bits of the result are zero.
- R4: If any input bit at a position from 0 up to and including the distance is 1, result bit 0 is 1.
- R5: If all input bits at positions 0 through the distance are 0, the result equals the plain logical right shift of the input, so bit 0 is 0.
- R6: At distance 0 the result equals the input exactly.
- R7: The result is valid in the same evaluation step in which the inputs change, with no clock edge in between.
- R8: An all-zero input gives an all-zero result at any distance. An all-ones input at distance d gives ones in bit positions 0 through WIDTH-1-d and zeros above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dataIn | input | WIDTH | Word to be aligned |
| shiftDist | input | DIST_W | Right-shift distance, unsigned |
| dataOut | output | WIDTH | Shifted word with the sticky indicator merged into bit 0 |

## Verification
The block holds no state, so a fault in its decoding or merge logic appears at `dataOut` in the same step in which the faulty input pattern is applied. A bad thermometer mask shows up as a wrong bit 0 only when the discarded bits are exactly the ones the mask mishandles. For that reason every distance is driven with many random words, and also with all-zero, all-ones and single-bit words placed right at the distance boundary. A fault in one of the shifter stages corrupts the upper bits only for distances that have that stage's bit set, and sweeping every distance exposes all such faults.

// File: rtl/align_shift_pkg.sv
package align_shift_pkg;

  localparam int DEFAULT_WIDTH = 32;

  // Width of a distance field able to encode 0 .. width-1.
  function automatic int distBits(input int width);
    int n;
    n = 0;
    while ((1 << n) < width) n++;
    return (n < 1) ? 1 : n;
  endfunction

endpackage

// File: rtl/align_shift_ctrl.sv
module align_shift_ctrl #(
  parameter int WIDTH  = align_shift_pkg::DEFAULT_WIDTH,
  parameter int DIST_W = align_shift_pkg::distBits(WIDTH)
) (
  input  logic [DIST_W-1:0] shiftDist,
  output logic [WIDTH-1:0]  stickyMask,
  output logic [DIST_W-1:0] stageEn
);

  // Thermometer code: bit i is set when i <= distance.
  // This covers every position that is shifted out, plus the one that
  // lands in bit 0.
  for (genvar i = 0; i < WIDTH; i++) begin : g_therm
    assign stickyMask[i] = (int'(shiftDist) >= i);
  end

  // Each stage of the log shifter is enabled by one distance bit.
  for (genvar k = 0; k < DIST_W; k++) begin : g_stage
    assign stageEn[k] = shiftDist[k];
  end

  always_comb begin
    assert_therm_count_R4: assert ($countones(stickyMask) == int'(shiftDist) + 1)
      else $error("sticky mask population does not match distance");
    assert_therm_base_R6: assert (stickyMask[0] == 1'b1)
      else $error("sticky mask must always cover bit 0");
  end

endmodule

// File: rtl/align_shift_dpath.sv
module align_shift_dpath #(
  parameter int WIDTH  = align_shift_pkg::DEFAULT_WIDTH,
  parameter int DIST_W = align_shift_pkg::distBits(WIDTH)
) (
  input  logic [WIDTH-1:0]  dataIn,
  input  logic [WIDTH-1:0]  stickyMask,
  input  logic [DIST_W-1:0] stageEn,
  output logic [WIDTH-1:0]  dataOut
);

  logic [WIDTH-1:0] stageVal [DIST_W+1];
  logic             stickyBit;

  assign stageVal[0] = dataIn;

  for (genvar k = 0; k < DIST_W; k++) begin : g_shift
    localparam int STEP = 1 << k;
    assign stageVal[k+1] = stageEn[k] ? (stageVal[k] >> STEP) : stageVal[k];
  end

  assign stickyBit = |(dataIn & stickyMask);
  assign dataOut   = {stageVal[DIST_W][WIDTH-1:1], stageVal[DIST_W][0] | stickyBit};

  always_comb begin
    assert_clear_lsb_R5: assert (stickyBit || (dataOut[0] == 1'b0))
      else $error("result LSB set although no sticky bit present");
    assert_zero_word_R8: assert ((dataIn != '0) || (dataOut == '0))
      else $error("zero input gave nonzero result");
  end

endmodule

// File: rtl/align_sticky_shifter.sv
module align_sticky_shifter #(
  parameter int WIDTH  = align_shift_pkg::DEFAULT_WIDTH,
  parameter int DIST_W = align_shift_pkg::distBits(WIDTH)
) (
  input  logic [WIDTH-1:0]  dataIn,
  input  logic [DIST_W-1:0] shiftDist,
  output logic [WIDTH-1:0]  dataOut
);

  logic [WIDTH-1:0]  stickyMask;
  logic [DIST_W-1:0] stageEn;

  align_shift_ctrl #(.WIDTH(WIDTH), .DIST_W(DIST_W)) u_ctrl (
    .shiftDist (shiftDist),
    .stickyMask(stickyMask),
    .stageEn   (stageEn)
  );

  align_shift_dpath #(.WIDTH(WIDTH), .DIST_W(DIST_W)) u_dpath (
    .dataIn    (dataIn),
    .stickyMask(stickyMask),
    .stageEn   (stageEn),
    .dataOut   (dataOut)
  );

  always_comb begin
    assert_pass_through_R6: assert ((shiftDist != '0) || (dataOut == dataIn))
      else $error("distance zero must pass input unchanged");
    assert_top_zero_R3: assert ((shiftDist == '0) ||
                                ((dataOut >> (WIDTH - int'(shiftDist))) == '0))
      else $error("vacated top bits not zero");
    assert_sticky_lsb_R4: assert (dataOut[0] ==
                                  |(dataIn << (WIDTH - 1 - int'(shiftDist))))
      else $error("result LSB disagrees with discarded bits");
  end

endmodule

// File: tb/align_sticky_shifter_tb.sv
module align_sticky_shifter_tb;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] dataIn = '0;
  logic [4:0]   shiftDist = '0;
  logic [W-1:0] dataOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  align_sticky_shifter u_dut (
    .dataIn   (dataIn),
    .shiftDist(shiftDist),
    .dataOut  (dataOut)
  );

  // Behavioural reference: plain integer arithmetic.
  function automatic logic [W-1:0] refModel(input logic [W-1:0] a, input int d);
    longint unsigned wide, lost;
    wide = longint'(a);
    lost = wide & ((64'd2 << d) - 64'd1);
    wide = wide >> d;
    if (lost != 0) wide = wide | 64'd1;
    return wide[W-1:0];
  endfunction

  task automatic applyCheck(input logic [W-1:0] a, input int d, input string tag);
    logic [W-1:0] exp;
    @(negedge clk);
    dataIn = a;
    shiftDist = d[4:0];
    #1;  // same step: no clock edge between stimulus and sample (R7)
    exp = refModel(a, d);
    checks++;
    if (dataOut !== exp) begin
      failures++;
      $display("FAIL %s d=%0d in=%h actual=%h expected=%h", tag, d, a, dataOut, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Idle state: zero input, zero distance (R8)
    applyCheck('0, 0, "R8 idle");

    // Distance zero passes everything through (R6)
    applyCheck(32'hDEAD_BEEF, 0, "R6");
    applyCheck(32'hFFFF_FFFE, 0, "R6");
    applyCheck(32'h0000_0001, 0, "R6");

    for (int d = 0; d < W; d++) begin
      applyCheck('0, d, "R8 zeros");
      applyCheck('1, d, "R8 ones");
      // Single bit exactly at the boundary: lands in bit 0 (R4)
      applyCheck(W'(1) << d, d, "R4 boundary");
      // Single bit just above: shifted value, no sticky (R5)
      if (d < W - 1) applyCheck(W'(1) << (d + 1), d, "R5 above");
      // Only the lowest bit set among discarded ones (R4)
      applyCheck(32'h8000_0001, d, "R4 lowbit");
      // Top bits set, low clear: checks zero fill (R3)
      applyCheck(32'hF000_0000, d, "R3 fill");
      // Random sweep over every distance (R1, R2)
      for (int j = 0; j < 200; j++)
        applyCheck($urandom, d, "R1,R2,R3,R4,R5");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule